// File: doc/BRIEF.md
# Sixteen-Bit Reloading Interval Timer

This block is a down-counting interval timer with a reload latch. It holds a 16-bit counter, a 16-bit latch and a control byte, all reached through a byte-wide register port. The counter moves one step on each cycle where the slow-clock enable `tick_en` is high. A write to the upper counter byte copies the whole latch into the counter and starts a new count. When the count passes from zero to all-ones, the block sets a pending flag, which drives `irq`. It can also toggle a square-wave output on that event.

Two modes exist. In free-running mode the counter is refilled from the latch one step after it wraps, so the period is the latch value plus two steps. In single-shot mode the flag is raised only for the first wrap after a start, and the counter then keeps counting down without reloading. Software reads the low counter byte to acknowledge the flag. Reading the high byte leaves the flag alone, so software can poll the coarse count without losing an event.

Top module: `intv_timer`

## Requirements
- R1: After reset, the latch, the counter, the control byte and the flag are zero, and `irq` and `wave_out` are low.
- R2: A write to address 0 or address 2 updates only the low latch byte. The counter does not change.
- R3: A write to address 1 stores the high latch byte. On the same clock edge it loads the counter with {written byte, low latch byte} and clears the flag. The new count is visible at the next clock edge.
- R4: The counter decrements by one on each clock edge where `tick_en` is high. It holds its value while `tick_en` is low.
- R5: With control bit 6 set (free-running), the counter steps through 0 and then 0xFFFF, and on the next step it reloads the latch. A latch value N gives a period of N+2 steps.
- R6: The step from 0 to 0xFFFF sets the flag. The flag reads at bit 6 of the status register (address 5) and drives `irq`.
- R7: A read (`rd_en`) of address 0 returns the low counter byte and clears the flag. A read of address 1 returns the high counter byte and leaves the flag unchanged.
- R8: With control bit 6 clear (single-shot), only the first wrap after an address-1 write sets the flag. Later wraps do not set it, and the counter keeps decrementing through 0xFFFF with no reload.
- R9: With control bit 7 set, `wave_out` toggles on every wrap that sets the flag. With bit 7 clear it holds its value. An address-1 write drives it low.
- R10: Control bits 1:0 are stored and read back at address 4, but they do not change timer behaviour.
- R11: Register map. Address 0 reads the low counter byte. Address 1 reads the high counter byte. Address 2 reads and writes the low latch byte. Address 3 reads and writes the high latch byte without starting a count. Address 4 reads and writes the control byte. Address 5 is the read-only status register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counting enable, one pulse per timer step |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (carries read side effects) |
| addr | input | 3 | Register address |
| wdata | input | BYTE_W | Write data |
| rdata | output | BYTE_W | Read data, combinational from `addr` |
| irq | output | 1 | Pending wrap flag |
| wave_out | output | 1 | Square-wave output toggled on flagged wraps |

## Verification
A wrong count value shows up on the next read of address 0 or 1. A reload that fires one step early or late shifts the period, which shows within N+2 ticks as a wrong low byte straight after the wrap. A flag or arming state that is wrong shows at `irq` on the cycle after the wrap. Single-shot arming is only exposed by a second full wrap, so the bench runs a complete 65536-step lap to reach it.

// File: rtl/intv_timer_pkg.sv
package intv_timer_pkg;

   typedef enum logic [2:0] {
      A_CNT_LO = 3'd0,
      A_CNT_HI = 3'd1,
      A_LAT_LO = 3'd2,
      A_LAT_HI = 3'd3,
      A_CTRL   = 3'd4,
      A_STAT   = 3'd5
   } reg_addr_e;

   localparam int CTL_FREE  = 6;
   localparam int CTL_WAVE  = 7;
   localparam int STAT_FLAG = 6;

endpackage

// File: rtl/intv_timer_regs.sv
module intv_timer_regs
   import intv_timer_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [2:0]          addr,
   input  logic [BYTE_W-1:0]   wdata,
   input  logic [2*BYTE_W-1:0] cnt_q,
   input  logic                flag_q,
   output logic [2*BYTE_W-1:0] latch_q,
   output logic [2*BYTE_W-1:0] load_val,
   output logic [BYTE_W-1:0]   ctrl_q,
   output logic                load_stb,
   output logic                rd_lo_stb,
   output logic [BYTE_W-1:0]   rdata
);

   logic [BYTE_W-1:0] lat_lo, lat_hi, ctrl_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_lo <= '0;
         lat_hi <= '0;
         ctrl_r <= '0;
      end else if (wr_en) begin
         case (addr)
            A_CNT_LO, A_LAT_LO: lat_lo <= wdata;
            A_CNT_HI, A_LAT_HI: lat_hi <= wdata;
            A_CTRL:             ctrl_r <= wdata;
            default: ;
         endcase
      end
   end

   assign latch_q   = {lat_hi, lat_lo};
   assign load_val  = {wdata, lat_lo};
   assign ctrl_q    = ctrl_r;
   assign load_stb  = wr_en && (addr == A_CNT_HI);
   assign rd_lo_stb = rd_en && (addr == A_CNT_LO);

   always_comb begin
      rdata = '0;
      case (addr)
         A_CNT_LO: rdata = cnt_q[BYTE_W-1:0];
         A_CNT_HI: rdata = cnt_q[2*BYTE_W-1:BYTE_W];
         A_LAT_LO: rdata = lat_lo;
         A_LAT_HI: rdata = lat_hi;
         A_CTRL:   rdata = ctrl_r;
         A_STAT:   rdata[STAT_FLAG] = flag_q;
         default:  rdata = '0;
      endcase
   end

endmodule

// File: rtl/intv_timer_count.sv
module intv_timer_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             free_run,
   input  logic             load_stb,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] latch_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             wrap_evt
);

   logic [CNT_W-1:0] cnt_r;
   logic             wrap_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_r  <= '0;
         wrap_r <= 1'b0;
      end else if (load_stb) begin
         cnt_r  <= load_val;
         wrap_r <= 1'b0;
      end else if (tick_en) begin
         if (wrap_r && free_run) cnt_r <= latch_q;
         else                    cnt_r <= cnt_r - 1'b1;
         wrap_r <= (cnt_r == '0);
      end
   end

   assign cnt_q    = cnt_r;
   assign wrap_evt = tick_en && !load_stb && (cnt_r == '0);

   // R3
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |=> (cnt_q == $past(load_val)));

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !load_stb) |=> $stable(cnt_q));

   // R4
   dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !load_stb && !(wrap_r && free_run))
         |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

   // R5
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !load_stb && free_run && wrap_r) |=> (cnt_q == $past(latch_q)));

endmodule

// File: rtl/intv_timer_event.sv
module intv_timer_event #(
   parameter bit HAS_WAVE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic free_run,
   input  logic wave_en,
   input  logic load_stb,
   input  logic wrap_evt,
   input  logic rd_lo_stb,
   output logic flag_q,
   output logic wave_q
);

   logic armed_r, flag_r, fire;

   assign fire = wrap_evt && (free_run || armed_r);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_r <= 1'b0;
         flag_r  <= 1'b0;
      end else begin
         if (load_stb)      armed_r <= 1'b1;
         else if (wrap_evt) armed_r <= 1'b0;

         if (fire)                       flag_r <= 1'b1;
         else if (load_stb || rd_lo_stb) flag_r <= 1'b0;
      end
   end

   assign flag_q = flag_r;

   generate
      if (HAS_WAVE) begin : g_wave
         logic wave_r;
         always_ff @(posedge clk) begin
            if (!rst_n)                wave_r <= 1'b0;
            else if (load_stb)         wave_r <= 1'b0;
            else if (fire && wave_en)  wave_r <= ~wave_r;
         end
         assign wave_q = wave_r;

         // R9
         wave_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            load_stb |=> !wave_q);

         // R9
         wave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!wave_en && !load_stb) |=> $stable(wave_q));
      end else begin : g_nowave
         assign wave_q = 1'b0;
      end
   endgenerate

   // R6
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_evt && free_run) |=> flag_q);

   // R7
   flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lo_stb && !wrap_evt) |=> !flag_q);

   // R8
   one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!free_run && wrap_evt && !armed_r && !flag_q) |=> !flag_q);

endmodule

// File: rtl/intv_timer.sv
module intv_timer
   import intv_timer_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter bit HAS_WAVE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [2:0]        addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   output logic              irq,
   output logic              wave_out
);

   localparam int CNT_W = 2 * BYTE_W;

   generate
      if (BYTE_W < CTL_WAVE + 1) begin : g_width_bad
         $error("intv_timer: BYTE_W must hold control bit %0d", CTL_WAVE);
      end
   endgenerate

   logic [CNT_W-1:0]  cnt_q, latch_q, load_val;
   logic [BYTE_W-1:0] ctrl_q;
   logic              load_stb, rd_lo_stb, wrap_evt, flag_q, wave_q;

   intv_timer_regs #(.BYTE_W(BYTE_W)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .addr      (addr),
      .wdata     (wdata),
      .cnt_q     (cnt_q),
      .flag_q    (flag_q),
      .latch_q   (latch_q),
      .load_val  (load_val),
      .ctrl_q    (ctrl_q),
      .load_stb  (load_stb),
      .rd_lo_stb (rd_lo_stb),
      .rdata     (rdata)
   );

   intv_timer_count #(.CNT_W(CNT_W)) i_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .free_run (ctrl_q[CTL_FREE]),
      .load_stb (load_stb),
      .load_val (load_val),
      .latch_q  (latch_q),
      .cnt_q    (cnt_q),
      .wrap_evt (wrap_evt)
   );

   intv_timer_event #(.HAS_WAVE(HAS_WAVE)) i_event (
      .clk       (clk),
      .rst_n     (rst_n),
      .free_run  (ctrl_q[CTL_FREE]),
      .wave_en   (ctrl_q[CTL_WAVE]),
      .load_stb  (load_stb),
      .wrap_evt  (wrap_evt),
      .rd_lo_stb (rd_lo_stb),
      .flag_q    (flag_q),
      .wave_q    (wave_q)
   );

   assign irq      = flag_q;
   assign wave_out = wave_q;

   // R3
   start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_CNT_HI) |=> !irq);

endmodule

// File: tb/test_intv_timer.sv
`timescale 1ns/1ps
module test_intv_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq, wave_out;

   int n_chk = 0, n_bad = 0, cyc = 0;

   always #5 clk = ~clk;

   intv_timer i_intv_timer (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .wave_out(wave_out)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_chk = n_chk + 1;
         n_bad = n_bad + 1;
         $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
      n_chk = n_chk + 1;
      if (act !== exp) begin
         n_bad = n_bad + 1;
         $display("FAIL %s: act=%02h exp=%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
      addr = a; rd_en = 1'b1;
      #1 check(rdata, exp, req);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic tick(input int n);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   // {req, op, addr, data}; op 0 = write, 1 = read and compare, 2 = tick count
   localparam int NV = 19;
   localparam logic [23:0] VEC [NV] = '{
      24'h5_0_04_40,  // R5 free-running
      24'h2_0_00_03,  // R2 low latch write
      24'h2_1_01_00,  // R2 counter untouched
      24'h2_1_00_00,
      24'h2_1_02_03,
      24'h3_0_01_00,  // R3 start count 0x0003
      24'h3_1_00_03,
      24'h4_2_00_01,  // R4 one step
      24'h4_1_00_02,
      24'h4_2_00_02,
      24'h4_1_00_00,
      24'h6_1_05_00,  // R6 no flag at zero
      24'h6_2_00_01,
      24'h6_1_05_40,  // R6 flag at wrap
      24'h7_1_01_FF,  // R7 high read, no clear
      24'h7_1_05_40,
      24'h5_2_00_01,  // R5 reload after N+2 steps
      24'h5_1_00_03,  // R7 low read clears
      24'h7_1_05_00
   };

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(3'd4, 8'h00, "R1"); rd(3'd5, 8'h00, "R1");
      rd(3'd2, 8'h00, "R1"); rd(3'd3, 8'h00, "R1");
      rd(3'd0, 8'h00, "R1"); rd(3'd1, 8'h00, "R1");
      check({7'd0, irq}, 8'h00, "R1"); check({7'd0, wave_out}, 8'h00, "R1");

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d", VEC[i][23:20]);
         case (VEC[i][19:16])
            4'd0: wr(VEC[i][10:8], VEC[i][7:0]);
            4'd1: rd(VEC[i][10:8], VEC[i][7:0], tag);
            default: tick(int'(VEC[i][7:0]));
         endcase
      end

      // R11 high latch write at address 3 does not start the counter
      wr(3'd3, 8'h12); rd(3'd3, 8'h12, "R11"); rd(3'd1, 8'h00, "R11");
      wr(3'd2, 8'h34); rd(3'd2, 8'h34, "R11"); rd(3'd0, 8'h03, "R11");
      wr(3'd1, 8'h56); rd(3'd0, 8'h34, "R3"); rd(3'd1, 8'h56, "R3"); rd(3'd3, 8'h56, "R11");

      // R3 start write clears a pending flag; R4 hold without tick
      wr(3'd0, 8'h00); wr(3'd1, 8'h00); tick(1);
      check({7'd0, irq}, 8'h01, "R6");
      wr(3'd1, 8'h00); rd(3'd5, 8'h00, "R3");
      repeat (5) @(negedge clk);
      rd(3'd0, 8'h00, "R4");

      // R10 bits 1:0 stored, no effect on reload
      wr(3'd4, 8'h43); rd(3'd4, 8'h43, "R10");
      wr(3'd0, 8'h01); wr(3'd1, 8'h00); tick(3);
      check({7'd0, irq}, 8'h01, "R10"); rd(3'd0, 8'h01, "R10");

      // R9 wave output
      wr(3'd4, 8'hC0); wr(3'd0, 8'h01); wr(3'd1, 8'h00);
      check({7'd0, wave_out}, 8'h00, "R9");
      tick(2); check({7'd0, wave_out}, 8'h01, "R9");
      tick(3); check({7'd0, wave_out}, 8'h00, "R9");
      tick(3); check({7'd0, wave_out}, 8'h01, "R9");
      wr(3'd4, 8'h40);
      tick(3); check({7'd0, wave_out}, 8'h01, "R9");
      wr(3'd1, 8'h00); check({7'd0, wave_out}, 8'h00, "R9");

      // R8 single-shot
      wr(3'd4, 8'h80); wr(3'd0, 8'h01); wr(3'd1, 8'h00);
      tick(2);
      check({7'd0, irq}, 8'h01, "R8"); check({7'd0, wave_out}, 8'h01, "R8");
      tick(1); rd(3'd0, 8'hFE, "R8");
      tick(65535);
      check({7'd0, irq}, 8'h00, "R8"); check({7'd0, wave_out}, 8'h01, "R8");
      rd(3'd1, 8'hFF, "R8"); rd(3'd5, 8'h00, "R8");
      tick(1); rd(3'd0, 8'hFE, "R8");

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule